// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Zone Protection

This block translates virtual addresses into physical addresses. It compares each address against a fully associative set of software-managed entries. Each entry describes one page, and the page can be any of eight sizes: 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB or 16 MB, each four times the one before. Because the size is stored per entry, the tag-compare mask and the translation mask are also chosen per entry. Address bits below the page offset pass straight through to the physical address. Since the output address is physical, any cache placed after the block compares physical tags.

Software fills the buffer through a single write port. The port names the slot to fill and supplies the valid flag, tag, size code, physical page number, two permission bits and a zone number. Hardware never chooses a victim slot. A separate input clears every valid bit at once.

A lookup is purely combinational and returns its result in the same cycle. The result is a hit or miss flag, the index of the matching slot, the physical address, the entry's permission bits and its zone number. A 32-bit zone configuration word then decides, for each of 16 zones, whether the entry's own permission bits apply or are overridden. A denied access raises a fault alongside the hit.

Top module: `zoned_tlb`

## Requirements
- R1: The buffer holds 64 slots. A lookup compares against all valid slots in the same cycle and returns `lk_hit` together with the matching slot number on `lk_idx`.
- R2: The size code s (0 to 7) gives an offset width of 10+2s bits. The stored tag holds virtual address bits [31:10]. The low 2s bits of that tag are left out of the compare, and every bit from 10+2s upward must match.
- R3: On a hit, `lk_paddr` takes bits [31:10+2s] from the stored page number, placed at bit 10 and up. It takes bits [10+2s-1:0] from the virtual address.
- R4: A write lands on the clock edge that ends its cycle. A lookup made during the write cycle still sees the old contents of the slot.
- R5: `tlb_flush` clears every valid bit in one cycle. If a write occurs in the same cycle, the written slot takes the write's data and valid flag, and every other slot becomes invalid.
- R6: If more than one valid slot matches, `lk_multi` is 1 and the lowest-numbered matching slot supplies every lookup output.
- R7: On a miss, `lk_miss` is 1, and `lk_hit`, `lk_paddr`, `lk_idx`, `lk_exec`, `lk_write`, `lk_zone` and `lk_fault` are all 0.
- R8: Zone z uses bits [2z+1:2z] of `zone_cfg`. The field values are:
  - 00: every access faults.
  - 01: reads pass, writes need the entry's write bit, executes need its execute bit.
  - 10: only reads pass.
  - 11: nothing faults.
  The access kind comes from `lk_kind`: 00 read, 01 write, 10 execute, 11 read. A fault is raised only on a hit.
- R9: While reset is applied and after it is released, every slot is invalid, so every lookup misses.
- R10: A write changes only the slot it names. Every other slot keeps its contents and still translates as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write one slot at the next edge |
| wr_idx | input | 6 | Slot to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_tag | input | 22 | Virtual address bits [31:10] |
| wr_size | input | 3 | Page size code |
| wr_ppn | input | 22 | Physical address bits [31:10] |
| wr_exec | input | 1 | Execute permission bit |
| wr_write | input | 1 | Write permission bit |
| wr_zone | input | 4 | Protection zone number |
| tlb_flush | input | 1 | Clear all valid bits |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| zone_cfg | input | 32 | Two-bit action field per zone |
| lk_hit | output | 1 | A valid slot matched |
| lk_miss | output | 1 | No valid slot matched |
| lk_multi | output | 1 | More than one valid slot matched |
| lk_idx | output | 6 | Selected slot number |
| lk_paddr | output | 32 | Translated physical address |
| lk_exec | output | 1 | Execute bit of the selected slot |
| lk_write | output | 1 | Write bit of the selected slot |
| lk_zone | output | 4 | Zone number of the selected slot |
| lk_fault | output | 1 | Access denied after the zone check |

## Verification
Two pairs of functions can occur in the same cycle.

The first pair is a slot write and a flush. The bench fills several slots, then in one cycle raises `tlb_flush` and writes slot 5. It judges the result by looking up every previously loaded address. Only the address written in that cycle should hit, and it should return its new page number.

The second pair is a lookup and a write to the slot that lookup would match. The bench samples the lookup before the edge and expects the old contents, then samples again after the edge and expects the new contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int BASE_OFF = 10;
  localparam int TAG_W    = VA_W - BASE_OFF;
  localparam int SIZE_W   = 3;
  localparam int ZONE_W   = 4;
  localparam int ZONES    = 1 << ZONE_W;

  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic [TAG_W-1:0]  ppn;
    logic              ex;
    logic              wr;
    logic [ZONE_W-1:0] zone;
  } slot_t;

  // ones on the tag bits that take part in the compare for size code s
  function automatic logic [TAG_W-1:0] tag_mask(input logic [SIZE_W-1:0] s);
    return ~((TAG_W'(1) << {s, 1'b0}) - TAG_W'(1));
  endfunction

  // ones on the address bits that pass through untranslated
  function automatic logic [VA_W-1:0] off_mask(input logic [SIZE_W-1:0] s);
    return (VA_W'(1) << (BASE_OFF + 2 * int'(s))) - VA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  slot_t               wr_slot,
  input  logic                flush,
  input  logic [TAG_W-1:0]    va_tag,
  output logic [SLOTS-1:0]    match,
  output slot_t [SLOTS-1:0]   slots
);
  logic [SLOTS-1:0] valid_q, valid_d;
  slot_t [SLOTS-1:0] body_q;

  always_comb begin
    valid_d = flush ? '0 : valid_q;
    if (wr_en) valid_d[wr_idx] = wr_slot.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (sel) body_q[i] <= wr_slot;
      end
      always_comb begin
        slots[i]       = body_q[i];
        slots[i].valid = valid_q[i];
      end
      assign match[i] = valid_q[i] &&
        (((va_tag ^ body_q[i].tag) & tag_mask(body_q[i].size)) == '0);
    end
  endgenerate

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slots[$past(wr_idx)].valid == $past(wr_slot.valid)) &&
              (slots[$past(wr_idx)].ppn == $past(wr_slot.ppn)));
  a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> (match == '0));
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int SLOTS = 64,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS-1:0]    match,
  output logic                hit,
  output logic                multi,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    hit   = 1'b0;
    multi = 1'b0;
    idx   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match[i]) begin
        if (hit) multi = 1'b1;
        else begin
          hit = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end
  end

  a_r6_multi_count: assert property (@(posedge clk) disable iff (!rst_n)
    multi == ($countones(match) > 1));
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[idx]);
endmodule

// File: rtl/tlb_zone_gate.sv
module tlb_zone_gate
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [1:0]        kind,
  input  logic              ent_ex,
  input  logic              ent_wr,
  input  logic [ZONE_W-1:0] zone,
  input  logic [2*ZONES-1:0] zone_cfg,
  output logic              fault
);
  typedef enum logic [1:0] {
    Z_DENY = 2'b00, Z_ENTRY = 2'b01, Z_READ = 2'b10, Z_ALL = 2'b11
  } zact_e;

  zact_e act;
  logic  is_wr, is_ex, deny;

  always_comb begin
    act   = zact_e'(zone_cfg[2*zone +: 2]);
    is_wr = (kind == 2'b01);
    is_ex = (kind == 2'b10);
    unique case (act)
      Z_DENY:  deny = 1'b1;
      Z_ENTRY: deny = (is_wr && !ent_wr) || (is_ex && !ent_ex);
      Z_READ:  deny = is_wr || is_ex;
      Z_ALL:   deny = 1'b0;
    endcase
    fault = hit && deny;
  end

  a_r8_deny_zone: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && zone_cfg[2*zone +: 2] == 2'b00) |-> fault);
  a_r8_open_zone: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_cfg[2*zone +: 2] == 2'b11) |-> !fault);
endmodule

// File: rtl/zoned_tlb.sv
module zoned_tlb
  import tlb_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [21:0]       wr_tag,
  input  logic [2:0]        wr_size,
  input  logic [21:0]       wr_ppn,
  input  logic              wr_exec,
  input  logic              wr_write,
  input  logic [3:0]        wr_zone,
  input  logic              tlb_flush,
  input  logic [31:0]       lk_vaddr,
  input  logic [1:0]        lk_kind,
  input  logic [31:0]       zone_cfg,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [31:0]       lk_paddr,
  output logic              lk_exec,
  output logic              lk_write,
  output logic [3:0]        lk_zone,
  output logic              lk_fault
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  slot_t              wr_slot;
  logic [SLOTS-1:0]   match;
  slot_t [SLOTS-1:0]  slots;
  logic               hit, multi, fault;
  logic [IDX_W-1:0]   idx;
  slot_t              sel;
  logic [VA_W-1:0]    omask;

  always_comb begin
    wr_slot = '{valid: wr_valid, tag: wr_tag, size: wr_size, ppn: wr_ppn,
                ex: wr_exec, wr: wr_write, zone: wr_zone};
  end

  tlb_store #(.SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_slot(wr_slot), .flush(tlb_flush), .va_tag(lk_vaddr[VA_W-1:BASE_OFF]),
    .match(match), .slots(slots)
  );

  tlb_pick #(.SLOTS(SLOTS)) u_pick (
    .clk(clk), .rst_n(rst_sn), .match(match), .hit(hit), .multi(multi), .idx(idx)
  );

  always_comb begin
    sel   = hit ? slots[idx] : '0;
    omask = off_mask(sel.size);
  end

  tlb_zone_gate u_zone (
    .clk(clk), .rst_n(rst_sn), .hit(hit), .kind(lk_kind), .ent_ex(sel.ex),
    .ent_wr(sel.wr), .zone(sel.zone), .zone_cfg(zone_cfg), .fault(fault)
  );

  always_comb begin
    lk_hit   = hit;
    lk_miss  = !hit;
    lk_multi = multi;
    lk_idx   = idx;
    lk_exec  = sel.ex;
    lk_write = sel.wr;
    lk_zone  = sel.zone;
    lk_fault = fault;
    lk_paddr = hit ? (({sel.ppn, {BASE_OFF{1'b0}}} & ~omask) | (lk_vaddr & omask))
                   : '0;
  end

  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    lk_miss |-> (lk_paddr == '0) && !lk_fault && !lk_multi && (lk_zone == '0));
  a_r9_reset_empty: assert property (@(posedge clk)
    !rst_sn |-> lk_miss);
  a_r1_hit_slot_matches: assert property (@(posedge clk) disable iff (!rst_sn)
    lk_hit |-> match[lk_idx]);
endmodule

// File: tb/zoned_tlb_test.sv
module zoned_tlb_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_en, wr_valid, wr_exec, wr_write, tlb_flush;
  logic [5:0] wr_idx;
  logic [21:0] wr_tag, wr_ppn;
  logic [2:0] wr_size;
  logic [3:0] wr_zone;
  logic [31:0] lk_vaddr, zone_cfg;
  logic [1:0] lk_kind;
  logic lk_hit, lk_miss, lk_multi, lk_exec, lk_write, lk_fault;
  logic [5:0] lk_idx;
  logic [31:0] lk_paddr;
  logic [3:0] lk_zone;

  int checks = 0, fails = 0;
  bit done = 0;

  zoned_tlb uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic v, input logic [31:0] va,
                     input int s, input logic [31:0] pa, input logic ex,
                     input logic wr, input int z);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_valid = v; wr_tag = va[31:10];
    wr_size = 3'(s); wr_ppn = pa[31:10]; wr_exec = ex; wr_write = wr; wr_zone = 4'(z);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k);
    lk_vaddr = va; lk_kind = k;
    #1;
  endtask

  function automatic logic [31:0] xlate(input logic [31:0] va, input logic [31:0] pa, input int s);
    logic [31:0] m;
    m = (32'd1 << (10 + 2 * s)) - 1;
    return (pa & ~m) | (va & m);
  endfunction

  function automatic logic va_base_ok(input int s);
    return s >= 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, pa;
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_tag = 0; wr_size = 0;
    wr_ppn = 0; wr_exec = 0; wr_write = 0; wr_zone = 0; tlb_flush = 0;
    lk_vaddr = 32'h1234_5678; lk_kind = 0; zone_cfg = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    look(32'h1234_5678, 0);
    chk("R9 miss in reset", {31'd0, lk_miss}, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    look(32'h0000_0000, 0);
    chk("R9 miss after reset", {31'd0, lk_miss}, 1);
    chk("R7 paddr zero on miss", lk_paddr, 0);
    chk("R7 idx zero on miss", {26'd0, lk_idx}, 0);

    // R2/R3/R1: every page size
    for (int s = 0; s < 8; s++) begin
      va = (32'(s + 1) << 28) | 32'h0ABC_DEF4;
      pa = (32'(s + 8) << 28) | 32'h0135_7000;
      put(s * 3, 1, va, s, pa, 1, 1, 0);
    end
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      va = (32'(s + 1) << 28) | 32'h0ABC_DEF4;
      pa = (32'(s + 8) << 28) | 32'h0135_7000;
      look(va, 0);
      chk("R1 hit", {31'd0, lk_hit}, 1);
      chk("R1 slot index", {26'd0, lk_idx}, 32'(s * 3));
      chk("R3 translated address", lk_paddr, xlate(va, pa, s));
      look(va ^ (32'd1 << (9 + 2 * s)), 0);
      chk("R2 bit below boundary ignored", {31'd0, lk_hit}, 1);
      chk("R3 offset passes through", lk_paddr, xlate(va ^ (32'd1 << (9 + 2 * s)), pa, s));
      look(va ^ (32'd1 << (10 + 2 * s)), 0);
      chk("R2 bit at boundary compared", {31'd0, lk_hit}, 0);
      chk("R7 miss flag", {31'd0, lk_miss}, 1);
    end

    // R4: write lands next edge; same-cycle lookup sees old state
    va = 32'hE000_4400;
    @(negedge clk);
    wr_en = 1; wr_idx = 20; wr_valid = 1; wr_tag = va[31:10]; wr_size = 0;
    wr_ppn = 22'h3FF; wr_exec = 0; wr_write = 0; wr_zone = 2;
    look(va, 0);
    chk("R4 old contents during write", {31'd0, lk_hit}, 0);
    @(negedge clk);
    wr_en = 0;
    look(va, 0);
    chk("R4 new contents after edge", {31'd0, lk_hit}, 1);
    chk("R4 zone stored", {28'd0, lk_zone}, 2);

    // R6: overlapping slots, lowest index wins
    va = 32'hF000_0800;
    put(40, 1, va, 0, 32'h1111_1000, 0, 0, 0);
    look(va, 0);
    chk("R6 single match", {31'd0, lk_multi}, 0);
    chk("R6 index 40", {26'd0, lk_idx}, 40);
    put(10, 1, va, 2, 32'h2222_2000, 0, 0, 0);
    look(va, 0);
    chk("R6 multi flag", {31'd0, lk_multi}, 1);
    chk("R6 lowest index", {26'd0, lk_idx}, 10);
    chk("R6 lowest slot data", lk_paddr, xlate(va, 32'h2222_2000, 2));
    put(10, 0, va, 2, 32'h2222_2000, 0, 0, 0);
    look(va, 0);
    chk("R6 back to single", {31'd0, lk_multi}, 0);
    chk("R10 slot 40 untouched", lk_paddr, xlate(va, 32'h1111_1000, 0));
    // R10: size entries still intact after other writes
    for (int s = 0; s < 8; s++) begin
      va = (32'(s + 1) << 28) | 32'h0ABC_DEF4;
      look(va, 0);
      chk("R10 other slots keep contents", {26'd0, lk_idx}, 32'(s * 3));
    end

    // R8: zone actions x access kinds x entry bits
    va = 32'h7700_0000;
    for (int eb = 0; eb < 4; eb++) begin
      put(50, 1, va, 1, 32'h5500_0000, eb[0], eb[1], 9);
      for (int f = 0; f < 4; f++) begin
        zone_cfg = 32'hFFFF_FFFF;
        zone_cfg[19:18] = 2'(f);
        for (int k = 0; k < 4; k++) begin
          logic exp;
          look(va, 2'(k));
          case (f)
            0: exp = 1;
            1: exp = (k == 1) ? !eb[1] : (k == 2) ? !eb[0] : 0;
            2: exp = (k == 1) || (k == 2);
            default: exp = 0;
          endcase
          chk("R8 zone fault", {31'd0, lk_fault}, {31'd0, exp});
        end
      end
      chk("R8 exec bit out", {31'd0, lk_exec}, eb[0]);
      chk("R8 write bit out", {31'd0, lk_write}, eb[1]);
    end
    zone_cfg = 32'h0;
    look(32'h0000_0000, 1);
    chk("R7 no fault on miss", {31'd0, lk_fault}, 0);
    zone_cfg = 32'hFFFF_FFFF;

    // R5: flush with same-cycle write
    va = 32'h9900_0C00;
    @(negedge clk);
    tlb_flush = 1; wr_en = 1; wr_idx = 5; wr_valid = 1; wr_tag = va[31:10];
    wr_size = 0; wr_ppn = 22'h2AAAA; wr_exec = 0; wr_write = 0; wr_zone = 0;
    @(negedge clk);
    tlb_flush = 0; wr_en = 0;
    look(va, 0);
    chk("R5 written slot survives", {26'd0, lk_idx}, 5);
    chk("R5 written slot data", lk_paddr, {22'h2AAAA, 10'h000});
    for (int s = 0; s < 8; s++) begin
      look((32'(s + 1) << 28) | 32'h0ABC_DEF4, 0);
      chk("R5 others cleared", {31'd0, lk_hit}, 0);
    end
    look(32'hF000_0800, 0);
    chk("R5 slot 40 cleared", {31'd0, lk_miss}, 1);
    @(negedge clk);
    tlb_flush = 1;
    @(negedge clk);
    tlb_flush = 0;
    look(va, 0);
    chk("R5 plain flush", {31'd0, lk_hit}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule